// File: doc/BRIEF.md
# Transmit FIR Pre-Emphasis Filter

This block shapes a serial binary stream for a lossy channel. Once per unit interval, marked by a one-cycle enable, it takes one data bit and produces a signed drive word for a downstream DAC. Each word is a weighted sum of four neighbouring symbols: one look-ahead (precursor) symbol, the main cursor symbol, and two earlier (postcursor) symbols. Weights of opposite sign on the side taps cancel intersymbol interference on both sides of each pulse. This trades peak drive swing for a wider received eye.

Each bit is treated as a ±1 symbol, so every tap product is a choice between +w and −w. A four-symbol delay line feeds a registered bank of sign-selected products, and a saturating adder stage follows it. A small fill state machine holds the output at zero until every tap position holds a real symbol. The state machine has two states. PRIME is entered on reset and counts enabled intervals. It takes the transition "window full" to STREAM on the fifth enabled interval after reset. STREAM is left only through reset. Weights come from a parallel coefficient bus. They are captured only on an enabled interval, so every output word uses one consistent weight set.

Top module: `txfir_preemph`

## Requirements
- R1: While reset is asserted, and after it is released, `drive_level` is 0 and the filter is in PRIME.
- R2: A data bit of 1 counts as +1 and a bit of 0 counts as −1. Each tap therefore adds +w or −w of its weight w. An all-ones stream yields the sum of the weights, and an all-zeros stream yields its negative.
- R3: `tap_weights` bits [8i+7:8i] hold the signed weight of tap i. Tap 0 is the precursor, tap 1 the main cursor, tap 2 the first postcursor and tap 3 the second postcursor. Number the enabled edges since reset k = 0, 1, 2… and let x(n) be the ±1 symbol sampled at edge n. After edge k ≥ 5, the output is w0·x(k−2) + w1·x(k−3) + w2·x(k−4) + w3·x(k−5). That is two intervals after a symbol reaches the cursor position.
- R4: A single 1 inside a run of 0s produces four consecutive output words. Each one departs from the all-zeros level −Σw by 2·w0, 2·w1, 2·w2 and then 2·w3.
- R5: The 10-bit output saturates. Sums above +511 give +511 (all weights −128 with all-zero data), and −512 is reproduced exactly (all weights −128 with all-one data).
- R6: The weight bus is sampled only on enabled edges. The weights sampled at edge k set the output after edge k+2, and all four terms of one output word use that single sample. Weights may change on every interval.
- R7: In cycles with `ui_en` low, `drive_level` holds its value, and `serial_bit` and `tap_weights` have no effect on any later output.
- R8: After reset, the output is 0 following enabled edges 0 through 4. The filter moves from PRIME to STREAM at edge 4 and reaches STREAM from edge 5 onward. It stays in STREAM until the next reset, and a later reset restarts the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ui_en | input | 1 | One-cycle strobe marking a unit-interval boundary |
| serial_bit | input | 1 | Data symbol, sampled when `ui_en` is high |
| tap_weights | input | 32 | Four signed 8-bit tap weights, tap 0 in the low byte |
| drive_level | output | 10 | Signed saturated drive word for the DAC |

## Verification
The sign mapping is checked with constant all-ones and all-zeros streams (R2). An isolated 1 in a run of 0s shows each tap's position and order in time (R4), which a constant stream cannot do. Alternating and random streams, with the weights changed every interval, tell a correct per-word weight sample apart from an output word that mixes old and new weights (R6). All weights at −128 drive both rails of the adder (R5). Random idle gaps with garbage on the data and weight inputs, plus a mid-run reset, check the hold behaviour (R7) and the refill (R8).

// File: rtl/txfir_pkg.sv
package txfir_pkg;
    typedef enum logic [0:0] {
        PRIME  = 1'b0,
        STREAM = 1'b1
    } fill_state_e;
endpackage

// File: rtl/txfir_delay_line.sv
module txfir_delay_line #(
    parameter int NTAPS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             bit_in,
    output logic [NTAPS-1:0] taps
);
    // taps[0] is the newest symbol (precursor position)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            taps <= '0;
        else if (adv)
            taps <= {taps[NTAPS-2:0], bit_in};
    end
endmodule

// File: rtl/txfir_tap_bank.sv
module txfir_tap_bank #(
    parameter int NTAPS = 4,
    parameter int CW    = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      adv,
    input  logic [NTAPS*CW-1:0]       weights_in,
    input  logic [NTAPS-1:0]          taps,
    output logic [NTAPS*CW-1:0]       weights_live,
    output logic [NTAPS*(CW+1)-1:0]   prod_flat
);
    localparam int PW = CW + 1;

    logic [NTAPS*CW-1:0] wt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wt_q <= '0;
        else if (adv)
            wt_q <= weights_in;
    end

    assign weights_live = wt_q;

    for (genvar g = 0; g < NTAPS; g++) begin : g_tap
        logic signed [PW-1:0] wide;
        logic signed [PW-1:0] prod_q;

        assign wide = {wt_q[g*CW+CW-1], wt_q[g*CW +: CW]};

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                prod_q <= '0;
            else if (adv)
                prod_q <= taps[g] ? wide : -wide;
        end

        assign prod_flat[g*PW +: PW] = prod_q;
    end
endmodule

// File: rtl/txfir_sum_sat.sv
module txfir_sum_sat #(
    parameter int NTAPS = 4,
    parameter int CW    = 8,
    parameter int OW    = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     adv,
    input  logic                     clear,
    input  logic [NTAPS*(CW+1)-1:0]  prod_flat,
    output logic signed [OW-1:0]     level
);
    localparam int PW   = CW + 1;
    localparam int SW   = PW + $clog2(NTAPS);
    localparam int AW   = (SW > OW) ? SW : OW;
    localparam int HI_I = 2 ** (OW - 1) - 1;
    localparam logic signed [AW-1:0] HI = AW'(HI_I);
    localparam logic signed [AW-1:0] LO = AW'(-HI_I - 1);

    logic signed [AW-1:0] acc;
    logic signed [OW-1:0] clipped;

    always_comb begin
        acc = '0;
        for (int i = 0; i < NTAPS; i++) begin
            acc = acc + {{(AW-PW){prod_flat[i*PW+PW-1]}}, prod_flat[i*PW +: PW]};
        end
    end

    if (AW > OW) begin : g_clip
        always_comb begin
            if (acc > HI)
                clipped = HI[OW-1:0];
            else if (acc < LO)
                clipped = LO[OW-1:0];
            else
                clipped = acc[OW-1:0];
        end
    end else begin : g_pass
        assign clipped = acc[OW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            level <= '0;
        else if (adv)
            level <= clear ? '0 : clipped;
    end
endmodule

// File: rtl/txfir_preemph.sv
module txfir_preemph #(
    parameter int NPRE  = 1,
    parameter int NPOST = 2,
    parameter int CW    = 8,
    parameter int OW    = 10,
    localparam int NTAPS = NPRE + 1 + NPOST
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ui_en,
    input  logic                  serial_bit,
    input  logic [NTAPS*CW-1:0]   tap_weights,
    output logic signed [OW-1:0]  drive_level
);
    import txfir_pkg::*;

    localparam int CNTW = $clog2(NTAPS + 1);
    localparam logic [CNTW-1:0] LAST_PRIME = CNTW'(NTAPS);

    fill_state_e            state_q, state_d;
    logic [CNTW-1:0]        cnt_q, cnt_d;
    logic                   hold_zero;
    logic [NTAPS-1:0]       taps;
    logic [NTAPS*CW-1:0]    weights_live;
    logic [NTAPS*(CW+1)-1:0] prod_flat;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PRIME;
            cnt_q   <= '0;
        end else if (ui_en) begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        hold_zero = 1'b1;
        unique case (state_q)
            PRIME: begin
                hold_zero = 1'b1;
                if (cnt_q == LAST_PRIME)
                    state_d = STREAM;
                else
                    cnt_d = cnt_q + 1'b1;
            end
            STREAM: begin
                hold_zero = 1'b0;
            end
            default: begin
                state_d = PRIME;
            end
        endcase
    end

    txfir_delay_line #(.NTAPS(NTAPS)) u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (ui_en),
        .bit_in (serial_bit),
        .taps   (taps)
    );

    txfir_tap_bank #(.NTAPS(NTAPS), .CW(CW)) u_taps (
        .clk          (clk),
        .rst_n        (rst_n),
        .adv          (ui_en),
        .weights_in   (tap_weights),
        .taps         (taps),
        .weights_live (weights_live),
        .prod_flat    (prod_flat)
    );

    txfir_sum_sat #(.NTAPS(NTAPS), .CW(CW), .OW(OW)) u_sum (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (ui_en),
        .clear     (hold_zero),
        .prod_flat (prod_flat),
        .level     (drive_level)
    );
endmodule

// File: rtl/txfir_checks.sv
module txfir_checks #(
    parameter int NTAPS = 4,
    parameter int CW    = 8,
    parameter int OW    = 10
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    ui_en,
    input logic                    serial_bit,
    input logic [NTAPS*CW-1:0]     tap_weights,
    input logic signed [OW-1:0]    drive_level,
    input txfir_pkg::fill_state_e  state_q,
    input logic [NTAPS-1:0]        taps,
    input logic [NTAPS*CW-1:0]     weights_live
);
    import txfir_pkg::*;

    a_r7_level_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !ui_en |=> $stable(drive_level));

    a_r6_weights_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !ui_en |=> $stable(weights_live));

    a_r6_weights_load_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        ui_en |=> weights_live == $past(tap_weights));

    a_r8_zero_while_priming: assert property (@(posedge clk) disable iff (!rst_n)
        (ui_en && state_q == PRIME) |=> drive_level == '0);

    a_r8_stream_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == STREAM |=> state_q == STREAM);

    a_r3_newest_tap_takes_bit: assert property (@(posedge clk) disable iff (!rst_n)
        ui_en |=> taps[0] == $past(serial_bit));
endmodule

bind txfir_preemph txfir_checks #(.NTAPS(NTAPS), .CW(CW), .OW(OW)) u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .ui_en        (ui_en),
    .serial_bit   (serial_bit),
    .tap_weights  (tap_weights),
    .drive_level  (drive_level),
    .state_q      (state_q),
    .taps         (taps),
    .weights_live (weights_live)
);

// File: tb/tb_txfir_preemph.sv
module tb_txfir_preemph;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               ui_en = 1'b0;
    logic               serial_bit = 1'b0;
    logic [31:0]        tap_weights = '0;
    logic signed [9:0]  drive_level;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    int          xs[$];
    logic [31:0] cs[$];
    int          exp_q[$];
    string       tag_q[$];
    int          last_level = 0;
    bit          en_q = 1'b0;

    always #10 clk = ~clk;

    txfir_preemph dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ui_en       (ui_en),
        .serial_bit  (serial_bit),
        .tap_weights (tap_weights),
        .drive_level (drive_level)
    );

    function automatic logic [31:0] pack_w(int w0, int w1, int w2, int w3);
        logic [7:0] b0, b1, b2, b3;
        b0 = w0[7:0]; b1 = w1[7:0]; b2 = w2[7:0]; b3 = w3[7:0];
        return {b3, b2, b1, b0};
    endfunction

    function automatic int model_at(int k);
        int s;
        logic [31:0] c;
        if (k < 5) return 0;
        c = cs[k-2];
        s = 0;
        for (int i = 0; i < 4; i++) begin
            s += int'($signed(c[8*i +: 8])) * xs[k-2-i];
        end
        if (s > 511) s = 511;
        if (s < -512) s = -512;
        return s;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: level actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // driver: one enabled interval, then idle cycles with garbage inputs
    task automatic send(bit d, logic [31:0] w, int gap, string tag);
        @(negedge clk);
        serial_bit  = d;
        tap_weights = w;
        ui_en       = 1'b1;
        xs.push_back(d ? 1 : -1);
        cs.push_back(w);
        exp_q.push_back(model_at(xs.size() - 1));
        tag_q.push_back(xs.size() <= 5 ? "R8" : tag);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            ui_en       = 1'b0;
            serial_bit  = 1'($urandom);
            tap_weights = $urandom;
        end
    endtask

    task automatic go_idle(int n);
        @(negedge clk);
        ui_en = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        ui_en = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", int'(drive_level), 0);
        @(negedge clk);
        rst_n = 1'b1;
        xs.delete();
        cs.delete();
        last_level = 0;
        @(negedge clk);
        check("R1", int'(drive_level), 0);
    endtask

    // monitor: capture enable at the edge, compare half a cycle later
    always @(posedge clk) en_q <= ui_en && rst_n;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (en_q) begin
                if (exp_q.size() == 0) begin
                    n_checks++;
                    n_fail++;
                    $display("FAIL R3: unexpected output actual=%0d expected=none", drive_level);
                end else begin
                    automatic int    e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    check(t, int'(drive_level), e);
                end
                last_level = int'(drive_level);
            end else begin
                check("R7", int'(drive_level), last_level);
            end
        end
    end

    initial begin
        logic [31:0] w;
        repeat (3) @(negedge clk);
        check("R1", int'(drive_level), 0);
        rst_n = 1'b1;

        // R8 fill then R2 constant streams
        w = pack_w(-5, 40, -10, 5);
        for (int i = 0; i < 10; i++) send(1'b1, w, 0, "R2");
        for (int i = 0; i < 10; i++) send(1'b0, w, 1, "R2");

        // R4 isolated one in zeros
        send(1'b1, w, 0, "R4");
        for (int i = 0; i < 8; i++) send(1'b0, w, 0, "R4");

        // R3 alternating with idle gaps (R7)
        w = pack_w(-12, 90, -30, 8);
        for (int i = 0; i < 16; i++) send(1'(i & 1), w, i % 3, "R3");

        // R6 random data, weights change every interval
        for (int i = 0; i < 60; i++) begin
            automatic logic [31:0] rw = $urandom;
            send(1'($urandom), rw, int'($urandom % 3), "R6");
        end

        // R5 saturation at both rails
        w = pack_w(-128, -128, -128, -128);
        for (int i = 0; i < 10; i++) send(1'b0, w, 0, "R5");
        for (int i = 0; i < 10; i++) send(1'b1, w, 0, "R5");
        w = pack_w(127, 127, 127, 127);
        for (int i = 0; i < 8; i++) send(1'b1, w, 0, "R5");
        go_idle(5);

        // mid-run reset and refill (R1, R8)
        do_reset();
        w = pack_w(20, -60, 15, -7);
        for (int i = 0; i < 12; i++) send(1'(i % 3 == 0), w, 2, "R3");
        go_idle(6);

        if (exp_q.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL R3: %0d outputs missing actual=0 expected=%0d", exp_q.size(), exp_q.size());
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule